// File: doc/BRIEF.md
# Two-Wide Issue Slot Pairing Checker

This block sits in the issue stage of a two-wide, in-order pipeline. Fetch supplies one aligned, 8-byte pair of 32-bit instructions per cycle. Slot 0 is the arithmetic slot and takes only ALU operations or branches. Slot 1 is the memory slot and takes only loads or stores, which compute their addresses on their own adder.

Each cycle the block decides what leaves the pair. It may issue both slots, only one of them, or neither. It raises a stall when a consumer depends on a load issued in the cycle before. It also tells fetch how far to advance: 0 bytes means hold the same pair on the inputs, 8 bytes means move to the next pair.

When the memory instruction reads a register written by the arithmetic instruction of the same pair, the pair is split over two cycles. This is done by a small controller with three states:
- ST_PAIR: normal evaluation.
- ST_SHADOW: a load issued last cycle and its destination is live.
- ST_TAIL: slot 0 of the held pair has issued and slot 1 is still pending.

Transitions:
- ST_PAIR or ST_SHADOW go to ST_TAIL on a split.
- ST_PAIR or ST_SHADOW go to ST_SHADOW when a load with a nonzero destination issues.
- ST_SHADOW goes to ST_PAIR on a stall, on an idle cycle, or on a pair with no load.
- ST_TAIL goes to ST_SHADOW or ST_PAIR once the pending memory instruction issues, depending on whether it is a load with a nonzero destination.

Top module: `dip_pair_issue`

## Requirements
- R1: After reset, with `pair_valid` low, `issue0`, `issue1` and `stall` are 0 and `fetch_adv` is 0.
- R2: Opcode is bits 31:26, rs is bits 25:21, rt is bits 20:16 and rd is bits 15:11. The instruction classes are:
  - opcode 0: register ALU op, writes rd, reads rs and rt.
  - opcode 001xxx: immediate ALU op, writes rt, reads rs.
  - opcode 00010x: branch, reads rs and rt, writes nothing.
  - opcode 100011: load, writes rt, reads rs.
  - opcode 101011: store, reads rs and rt.
  - Every other opcode fits neither slot.
- R3: A pair with a fitting slot 0, a fitting slot 1 and no dependency issues both slots in one cycle with `fetch_adv` = 8.
- R4: If slot 0 holds anything other than an ALU op or branch, only slot 1 issues (if it fits), and `fetch_adv` = 8.
- R5: If slot 1 holds anything other than a load or store, only slot 0 issues (if it fits). If both slots mismatch, nothing issues. In both cases `fetch_adv` = 8.
- R6: If the slot 1 instruction reads a nonzero register written by slot 0 of the same pair, the block first issues only slot 0 with `fetch_adv` = 0. On the next cycle, with the pair held, it issues only slot 1 with `fetch_adv` = 8.
- R7: Neither a slot 0 destination of register 0 nor a slot 0 branch ever causes a split.
- R8: If a load issued in the previous cycle writes register N (N≠0) and slot 0 of the current pair reads N, then `stall` = 1, no slot issues and `fetch_adv` = 0.
- R9: The same stall as in R8 occurs when only the slot 1 instruction reads N. This includes a load issued as the second half of a split.
- R10: A load to register 0 never causes a stall. A load followed by one cycle with `pair_valid` low causes no stall.
- R11: While `pair_valid` is low, nothing issues, `stall` is 0 and `fetch_adv` is 0.
- R12: A stall lasts exactly one cycle. The held pair issues on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_valid | input | 1 | Aligned instruction pair on the inputs is valid |
| insn0 | input | 32 | Slot 0 (ALU/branch) instruction |
| insn1 | input | 32 | Slot 1 (load/store) instruction |
| issue0 | output | 1 | Slot 0 issues this cycle |
| issue1 | output | 1 | Slot 1 issues this cycle |
| stall | output | 1 | Load-use stall; pair is held |
| fetch_adv | output | 4 | Bytes fetch advances: 0 or 8 |

## Verification
A wrong state shows at the ports one cycle after the decision that caused it.

- A stuck ST_TAIL shows as a missing or repeated slot 1 issue.
- A lost ST_SHADOW shows as a missing stall on the very next pair.
- A stale load register shows as a spurious stall or a missing one.

The directed scenarios place each consumer immediately after its producer, so every such fault appears within two cycles of the load or split that exposes it.

// File: rtl/dip_pkg.sv
package dip_pkg;

    localparam int REG_AW = 5;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_ALU,
        CL_BR,
        CL_LD,
        CL_ST
    } insn_cls_e;

    typedef struct packed {
        insn_cls_e          cls;
        logic               wr_en;
        logic [REG_AW-1:0]  wr_reg;
        logic               rd_a_en;
        logic [REG_AW-1:0]  rd_a;
        logic               rd_b_en;
        logic [REG_AW-1:0]  rd_b;
    } slot_info_t;

    typedef enum logic [1:0] {
        ST_PAIR,
        ST_SHADOW,
        ST_TAIL
    } iss_state_e;

endpackage

// File: rtl/dip_slot_decode.sv
module dip_slot_decode
    import dip_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] insn,
    output slot_info_t      info
);

    localparam int OPC_LSB = XLEN - 6;

    logic [5:0]        opc;
    logic [REG_AW-1:0] f_rs;
    logic [REG_AW-1:0] f_rt;
    logic [REG_AW-1:0] f_rd;
    logic              unused_low;

    assign opc        = insn[XLEN-1:OPC_LSB];
    assign f_rs       = insn[OPC_LSB-1 -: REG_AW];
    assign f_rt       = insn[OPC_LSB-1-REG_AW -: REG_AW];
    assign f_rd       = insn[OPC_LSB-1-2*REG_AW -: REG_AW];
    assign unused_low = ^insn[OPC_LSB-1-3*REG_AW:0];

    always_comb begin
        info     = '0;
        info.cls = CL_NONE;
        if (opc == 6'b000000) begin
            // register ALU op
            info.cls     = CL_ALU;
            info.wr_reg  = f_rd;
            info.wr_en   = (f_rd != '0);
            info.rd_a_en = 1'b1;
            info.rd_a    = f_rs;
            info.rd_b_en = 1'b1;
            info.rd_b    = f_rt;
        end else if (opc[5:3] == 3'b001) begin
            // immediate ALU op
            info.cls     = CL_ALU;
            info.wr_reg  = f_rt;
            info.wr_en   = (f_rt != '0);
            info.rd_a_en = 1'b1;
            info.rd_a    = f_rs;
        end else if (opc[5:1] == 5'b00010) begin
            // compare-and-branch
            info.cls     = CL_BR;
            info.rd_a_en = 1'b1;
            info.rd_a    = f_rs;
            info.rd_b_en = 1'b1;
            info.rd_b    = f_rt;
        end else if (opc == 6'b100011) begin
            // load word
            info.cls     = CL_LD;
            info.wr_reg  = f_rt;
            info.wr_en   = (f_rt != '0);
            info.rd_a_en = 1'b1;
            info.rd_a    = f_rs;
        end else if (opc == 6'b101011) begin
            // store word
            info.cls     = CL_ST;
            info.rd_a_en = 1'b1;
            info.rd_a    = f_rs;
            info.rd_b_en = 1'b1;
            info.rd_b    = f_rt;
        end
    end

endmodule

// File: rtl/dip_hazard_check.sv
module dip_hazard_check
    import dip_pkg::*;
(
    input  slot_info_t        s0,
    input  slot_info_t        s1,
    input  logic              ld_live,
    input  logic [REG_AW-1:0] ld_reg,
    output logic              use0,
    output logic              use1,
    output logic              intra
);

    function automatic logic reads_reg(input slot_info_t s, input logic [REG_AW-1:0] r);
        return (s.rd_a_en && (s.rd_a == r)) || (s.rd_b_en && (s.rd_b == r));
    endfunction

    always_comb begin
        use0  = ld_live && reads_reg(s0, ld_reg);
        use1  = ld_live && reads_reg(s1, ld_reg);
        intra = s0.wr_en && reads_reg(s1, s0.wr_reg);
    end

endmodule

// File: rtl/dip_pair_issue.sv
module dip_pair_issue
    import dip_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int SLOTS = 2,
    parameter int ADV_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pair_valid,
    input  logic [XLEN-1:0] insn0,
    input  logic [XLEN-1:0] insn1,
    output logic            issue0,
    output logic            issue1,
    output logic            stall,
    output logic [ADV_W-1:0] fetch_adv
);

    localparam int PAIR_BYTES = SLOTS * (XLEN / 8);

    logic [XLEN-1:0]   insn_arr [SLOTS];
    slot_info_t        info     [SLOTS];

    iss_state_e        state_q;
    iss_state_e        state_d;
    logic [REG_AW-1:0] ld_reg_q;
    logic              fit0;
    logic              fit1;
    logic              use0;
    logic              use1;
    logic              intra;
    logic              cap_ld;
    logic              mem_is_ld;

    assign insn_arr[0] = insn0;
    assign insn_arr[1] = insn1;

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_dec
            dip_slot_decode #(.XLEN(XLEN)) i_dec (
                .insn (insn_arr[s]),
                .info (info[s])
            );
        end
    endgenerate

    dip_hazard_check i_haz (
        .s0      (info[0]),
        .s1      (info[1]),
        .ld_live (state_q == ST_SHADOW),
        .ld_reg  (ld_reg_q),
        .use0    (use0),
        .use1    (use1),
        .intra   (intra)
    );

    assign fit0      = (info[0].cls == CL_ALU) || (info[0].cls == CL_BR);
    assign fit1      = (info[1].cls == CL_LD) || (info[1].cls == CL_ST);
    assign mem_is_ld = (info[1].cls == CL_LD) && info[1].wr_en;

    // state register and load destination tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_PAIR;
            ld_reg_q <= '0;
        end else begin
            state_q <= state_d;
            if (cap_ld) begin
                ld_reg_q <= info[1].wr_reg;
            end
        end
    end

    // outputs and next state
    always_comb begin
        issue0    = 1'b0;
        issue1    = 1'b0;
        stall     = 1'b0;
        fetch_adv = '0;
        state_d   = state_q;
        unique case (state_q)
            ST_PAIR, ST_SHADOW: begin
                if (!pair_valid) begin
                    state_d = ST_PAIR;
                end else if ((fit0 && use0) || (fit1 && use1)) begin
                    stall   = 1'b1;
                    state_d = ST_PAIR;
                end else if (fit0 && fit1 && intra) begin
                    issue0  = 1'b1;
                    state_d = ST_TAIL;
                end else begin
                    issue0    = fit0;
                    issue1    = fit1;
                    fetch_adv = ADV_W'(PAIR_BYTES);
                    state_d   = (fit1 && mem_is_ld) ? ST_SHADOW : ST_PAIR;
                end
            end
            ST_TAIL: begin
                if (pair_valid) begin
                    issue1    = fit1;
                    fetch_adv = ADV_W'(PAIR_BYTES);
                    state_d   = (fit1 && mem_is_ld) ? ST_SHADOW : ST_PAIR;
                end
            end
            default: state_d = ST_PAIR;
        endcase
        cap_ld = issue1 && mem_is_ld;
    end

endmodule

// File: rtl/dip_pair_issue_chk.sv
module dip_pair_issue_chk #(
    parameter int ADV_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pair_valid,
    input logic             issue0,
    input logic             issue1,
    input logic             stall,
    input logic [ADV_W-1:0] fetch_adv
);

    AST_STALL_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!issue0 && !issue1 && fetch_adv == '0)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> (!issue0 && !issue1 && !stall && fetch_adv == '0)); // R11

    AST_ADV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_adv == '0) || (fetch_adv == ADV_W'(8))); // R3

    AST_SPLIT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (issue0 && !issue1 && fetch_adv == '0) |=> !issue0); // R6

    AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall); // R12

    AST_STALL_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> $past(issue1)); // R9

endmodule

bind dip_pair_issue dip_pair_issue_chk #(.ADV_W(ADV_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pair_valid (pair_valid),
    .issue0     (issue0),
    .issue1     (issue1),
    .stall      (stall),
    .fetch_adv  (fetch_adv)
);

// File: tb/test_dip_pair_issue.sv
`timescale 1ns/1ps
module test_dip_pair_issue;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pair_valid = 1'b0;
    logic [31:0] insn0 = '0;
    logic [31:0] insn1 = '0;
    logic        issue0;
    logic        issue1;
    logic        stall;
    logic [3:0]  fetch_adv;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dip_pair_issue i_dip_pair_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .pair_valid (pair_valid),
        .insn0      (insn0),
        .insn1      (insn1),
        .issue0     (issue0),
        .issue1     (issue1),
        .stall      (stall),
        .fetch_adv  (fetch_adv)
    );

    function automatic logic [31:0] op_add(input int rd, input int rs, input int rt);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h21};
    endfunction
    function automatic logic [31:0] op_addi(input int rt, input int rs);
        return {6'b001000, 5'(rs), 5'(rt), 16'h0004};
    endfunction
    function automatic logic [31:0] op_beq(input int rs, input int rt);
        return {6'b000100, 5'(rs), 5'(rt), 16'h0010};
    endfunction
    function automatic logic [31:0] op_lw(input int rt, input int rs);
        return {6'b100011, 5'(rs), 5'(rt), 16'h0000};
    endfunction
    function automatic logic [31:0] op_sw(input int rt, input int rs);
        return {6'b101011, 5'(rs), 5'(rt), 16'h0000};
    endfunction

    // drive one cycle, check combinational outputs mid-cycle
    task automatic step(input logic pv, input logic [31:0] a, input logic [31:0] b,
                        input logic e0, input logic e1, input logic es,
                        input logic [3:0] eadv, input string tag);
        @(negedge clk);
        pair_valid = pv;
        insn0      = a;
        insn1      = b;
        #2;
        checks++;
        if (issue0 !== e0 || issue1 !== e1 || stall !== es || fetch_adv !== eadv) begin
            errors++;
            $display("FAIL %s: got issue0=%b issue1=%b stall=%b adv=%0d, expected %b %b %b %0d",
                     tag, issue0, issue1, stall, fetch_adv, e0, e1, es, eadv);
        end
    endtask

    task automatic idle();
        step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 4'd0, "R11 idle");
    endtask

    task automatic t_reset();
        step(1'b0, '0, '0, 0, 0, 0, 4'd0, "R1 reset state");
        step(1'b0, op_add(1, 2, 3), op_lw(4, 5), 0, 0, 0, 4'd0, "R11 valid low ignores pair");
    endtask

    task automatic t_clean();
        // R2 R3: register ALU with a store, immediate ALU with a load
        step(1'b1, op_add(3, 1, 2), op_sw(6, 5), 1, 1, 0, 4'd8, "R3 add+sw");
        step(1'b1, op_addi(7, 1), op_lw(4, 5), 1, 1, 0, 4'd8, "R2 addi+lw");
        step(1'b1, op_add(9, 1, 2), op_sw(1, 2), 1, 1, 0, 4'd8, "R3 unrelated after load");
    endtask

    task automatic t_mismatch();
        step(1'b1, op_lw(3, 1), op_sw(2, 1), 0, 1, 0, 4'd8, "R4 load in slot0");
        step(1'b1, op_add(3, 1, 2), op_add(4, 1, 2), 1, 0, 0, 4'd8, "R5 alu in slot1");
        step(1'b1, op_sw(3, 1), op_beq(1, 2), 0, 0, 0, 4'd8, "R5 both mismatched");
        step(1'b1, 32'hFC00_0000, op_sw(2, 1), 0, 1, 0, 4'd8, "R4 unknown opcode slot0");
    endtask

    task automatic t_split();
        step(1'b1, op_add(6, 1, 2), op_sw(7, 6), 1, 0, 0, 4'd0, "R6 split first half base");
        step(1'b1, op_add(6, 1, 2), op_sw(7, 6), 0, 1, 0, 4'd8, "R6 split tail base");
        step(1'b1, op_addi(8, 1), op_sw(8, 2), 1, 0, 0, 4'd0, "R6 split first half data");
        step(1'b1, op_addi(8, 1), op_sw(8, 2), 0, 1, 0, 4'd8, "R6 split tail data");
    endtask

    task automatic t_nosplit();
        step(1'b1, op_add(0, 1, 2), op_sw(3, 0), 1, 1, 0, 4'd8, "R7 dest zero");
        step(1'b1, op_beq(1, 2), op_sw(1, 2), 1, 1, 0, 4'd8, "R7 branch slot0");
    endtask

    task automatic t_luse0();
        step(1'b1, op_add(2, 1, 3), op_lw(8, 1), 1, 1, 0, 4'd8, "R8 producer load");
        step(1'b1, op_add(9, 8, 1), op_sw(2, 3), 0, 0, 1, 4'd0, "R8 stall slot0 consumer");
        step(1'b1, op_add(9, 8, 1), op_sw(2, 3), 1, 1, 0, 4'd8, "R12 issue after stall");
    endtask

    task automatic t_luse1();
        step(1'b1, op_add(2, 1, 3), op_lw(10, 1), 1, 1, 0, 4'd8, "R9 producer load");
        step(1'b1, op_add(11, 1, 2), op_sw(10, 3), 0, 0, 1, 4'd0, "R9 stall slot1 consumer");
        step(1'b1, op_add(11, 1, 2), op_sw(10, 3), 1, 1, 0, 4'd8, "R12 issue after stall");
        // load issued as the tail of a split
        step(1'b1, op_add(13, 1, 2), op_lw(14, 13), 1, 0, 0, 4'd0, "R6 split before load");
        step(1'b1, op_add(13, 1, 2), op_lw(14, 13), 0, 1, 0, 4'd8, "R6 tail load");
        step(1'b1, op_beq(14, 1), op_sw(1, 2), 0, 0, 1, 4'd0, "R9 stall after tail load");
        step(1'b1, op_beq(14, 1), op_sw(1, 2), 1, 1, 0, 4'd8, "R12 issue after stall");
    endtask

    task automatic t_nostall();
        step(1'b1, op_add(2, 1, 3), op_lw(0, 1), 1, 1, 0, 4'd8, "R10 load to r0");
        step(1'b1, op_add(4, 0, 0), op_sw(0, 0), 1, 1, 0, 4'd8, "R10 r0 reader no stall");
        step(1'b1, op_add(2, 1, 3), op_lw(12, 1), 1, 1, 0, 4'd8, "R10 load r12");
        idle();
        step(1'b1, op_add(4, 12, 1), op_sw(12, 2), 1, 1, 0, 4'd8, "R10 gap removes hazard");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_clean();
        idle();
        t_mismatch();
        t_split();
        t_nosplit();
        t_luse0();
        idle();
        t_luse1();
        idle();
        t_nostall();
        idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule